// File: doc/BRIEF.md
# Load/Store Address Sequencer

This unit carries out the data-movement instructions of a 16-bit load/store processor. The core hands it a fetched instruction word and the program counter, already advanced past that instruction, together with a `start` pulse. The unit then forms an effective address in one of three ways. PC-relative mode adds a signed 9-bit offset to the PC. Base-plus-offset mode adds a signed 6-bit offset to a register. Indirect mode fetches a pointer from memory at PC plus offset.

The unit drives one word-wide memory port with a request/ready handshake. Loads end with a register write-back. Stores send register contents to memory. The address-only operation writes the computed address into a register and never touches memory.

The register file has one read port, and the unit steers its index itself. During address calculation the index is the base field, bits [8:6]. During the final memory access it is the data field, bits [11:9]. Register reads are taken as combinational.

Top module: `ldst_agu_seq`

## Requirements
- R1: After reset, `done`, `mem_req`, `wb_en` and `unsupported` are all low, and no request is made until `start` is seen.
- R2: Opcode 0010 (load) and opcode 0011 (store) use the address `pc_next` plus bits [8:0] sign-extended, taken modulo 2^16.
- R3: Opcode 0110 (load) and opcode 0111 (store) use the address of register bits [8:6] plus bits [5:0] sign-extended, taken modulo 2^16.
- R4: Opcode 1010 (indirect load) makes two reads. The first read is at `pc_next` plus sign-extended [8:0]. The second read is at the word the first read returned. The word from the second read is written back.
- R5: Opcode 1011 (indirect store) makes one read at `pc_next` plus sign-extended [8:0]. It then writes register [11:9] to the address that read returned.
- R6: Opcode 1110 writes `pc_next` plus sign-extended [8:0] to register [11:9] and makes no memory request. For example, `pc_next` = x3001 with offset 0x0FF gives x3100.
- R7: A store drives `mem_we` high and `mem_wdata` with the value of register [11:9] during its write access. A store makes no register write-back.
- R8: Once `mem_req` is raised, it stays high with `mem_addr` and `mem_we` unchanged until a cycle in which `mem_ready` is high.
- R9: `done` is high for exactly one cycle per instruction. `wb_en`, `wb_idx` (bits [11:9]) and `wb_data` are valid in that same cycle. Counting cycles after the `start` edge, `done` rises after 2 cycles for opcode 1110 and for unsupported opcodes, after 3 cycles for direct accesses, and after 4 cycles for indirect ones. Each cycle that ready is withheld adds one more.
- R10: Any opcode not listed above raises `unsupported` together with `done`. It makes no memory request and no register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin executing `instr`; sampled only when the unit is idle |
| instr | input | 16 | Instruction word |
| pc_next | input | 16 | PC already incremented past the instruction |
| rf_raddr | output | 3 | Register file read index |
| rf_rdata | input | 16 | Register file read data (combinational) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid while `mem_ready` is high |
| mem_ready | input | 1 | Memory completes the request this cycle |
| done | output | 1 | Instruction complete (one cycle) |
| unsupported | output | 1 | Opcode is not handled; valid with `done` |
| wb_en | output | 1 | Register write enable |
| wb_idx | output | 3 | Register write index |
| wb_data | output | 16 | Register write data |

## Verification
Every result of this unit is due at a cycle count after the `start` edge that follows from R9. That count is 2 for the address-only and unsupported cases, 3 for direct loads and stores, and 4 for indirect forms, plus the number of cycles the memory model holds back ready. The bench drives inputs and samples outputs on falling edges, starting its count from the edge that took `start`. It requires `done` in exactly the predicted cycle, reads the write-back outputs in that same cycle, and checks that `done` has dropped one cycle later. The memory model records each handshake's address, direction and data as it raises ready. This lets the access sequence, including the pointer read, be compared after completion against values computed from the requirements.

// File: rtl/ldst_agu_seq.sv
module ldst_agu_seq #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [15:0]  instr,
  input  logic [W-1:0] pc_next,
  output logic [2:0]   rf_raddr,
  input  logic [W-1:0] rf_rdata,
  output logic         mem_req,
  output logic         mem_we,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  input  logic [W-1:0] mem_rdata,
  input  logic         mem_ready,
  output logic         done,
  output logic         unsupported,
  output logic         wb_en,
  output logic [2:0]   wb_idx,
  output logic [W-1:0] wb_data
);
  localparam logic [3:0] OP_LD = 4'b0010, OP_ST = 4'b0011, OP_LDR = 4'b0110, OP_STR = 4'b0111;
  localparam logic [3:0] OP_LDI = 4'b1010, OP_STI = 4'b1011, OP_LEA = 4'b1110;

  typedef enum logic [2:0] {S_IDLE, S_CALC, S_PTR, S_ACC, S_WB} st_t;
  st_t state;

  logic [15:0]  ir;
  logic [W-1:0] pc_q, addr_q, data_q, ea, s9, s6;
  logic [3:0]   op;
  logic         is_ld, is_st, is_ind, is_base, is_lea, known;

  assign op      = ir[15:12];
  assign is_ld   = op == OP_LD || op == OP_LDR || op == OP_LDI;
  assign is_st   = op == OP_ST || op == OP_STR || op == OP_STI;
  assign is_ind  = op == OP_LDI || op == OP_STI;
  assign is_base = op == OP_LDR || op == OP_STR;
  assign is_lea  = op == OP_LEA;
  assign known   = is_ld || is_st || is_lea;

  assign s9 = {{(W-9){ir[8]}}, ir[8:0]};
  assign s6 = {{(W-6){ir[5]}}, ir[5:0]};
  assign ea = is_base ? rf_rdata + s6 : pc_q + s9;

  assign rf_raddr    = (state == S_CALC) ? ir[8:6] : ir[11:9];
  assign mem_req     = state == S_PTR || state == S_ACC;
  assign mem_we      = state == S_ACC && is_st;
  assign mem_addr    = addr_q;
  assign mem_wdata   = mem_we ? rf_rdata : '0;
  assign done        = state == S_WB;
  assign unsupported = done && !known;
  assign wb_en       = done && (is_ld || is_lea);
  assign wb_idx      = ir[11:9];
  assign wb_data     = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      ir     <= '0;
      pc_q   <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          ir    <= instr;
          pc_q  <= pc_next;
          state <= S_CALC;
        end
        S_CALC: begin
          addr_q <= ea;
          data_q <= ea;
          if (!known || is_lea) state <= S_WB;
          else if (is_ind)      state <= S_PTR;
          else                  state <= S_ACC;
        end
        S_PTR: if (mem_ready) begin
          addr_q <= mem_rdata;
          state  <= S_ACC;
        end
        S_ACC: if (mem_ready) begin
          if (!is_st) data_q <= mem_rdata;
          state <= S_WB;
        end
        S_WB:    state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !mem_req); // R9
  AST_LEA_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_CALC && is_lea |=> done && wb_en && !mem_req); // R6
  AST_UNSUP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_CALC && !known |=> done && unsupported && !wb_en && !mem_req); // R10
  AST_PTR_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_PTR && mem_ready |=> mem_req && mem_addr == $past(mem_rdata)); // R4
  AST_LOAD_WB: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_ACC && mem_ready && !mem_we |=> wb_en && wb_data == $past(mem_rdata)); // R9
endmodule

// File: tb/sim_ldst_agu_seq.sv
module sim_ldst_agu_seq;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, start, mem_req, mem_we, mem_ready, done, unsupported, wb_en;
  logic [15:0] instr, pc_next, rf_rdata, mem_addr, mem_wdata, mem_rdata, wb_data;
  logic [2:0]  rf_raddr, wb_idx;

  logic [15:0] rf_vals [8];
  assign rf_rdata = rf_vals[rf_raddr];

  ldst_agu_seq u0 (.*);

  int checks = 0, fails = 0;
  int mem_lat = 0, cnt = 0, nlog = 0, hold_err = 0;
  logic [15:0] hold_addr;
  logic [15:0] log_addr [4], log_wd [4];
  logic        log_we [4];

  function automatic logic [15:0] memf(logic [15:0] a);
    return {a[7:0], a[15:8]} ^ 16'h5A3C;
  endfunction

  always @(negedge clk) begin
    if (mem_ready) begin mem_ready = 1'b0; cnt = 0; end
    if (mem_req) begin
      if (cnt == 0) hold_addr = mem_addr;
      else if (mem_addr != hold_addr) hold_err++;
      if (cnt >= mem_lat) begin
        mem_ready = 1'b1;
        mem_rdata = memf(mem_addr);
        if (nlog < 4) begin
          log_addr[nlog] = mem_addr; log_we[nlog] = mem_we; log_wd[nlog] = mem_wdata;
        end
        nlog++;
      end else cnt++;
    end
  end

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run(logic [15:0] ins, logic [15:0] pc, int lat);
    logic [3:0]  op;
    logic [15:0] s9, s6, ea, ptr, xd;
    logic [15:0] ta [2], tw [2];
    logic        twe [2];
    int nt, elat, cyc;
    logic ewb, euns;
    logic [15:0] edata;
    string tag;
    op = ins[15:12];
    s9 = {{7{ins[8]}}, ins[8:0]};
    s6 = {{10{ins[5]}}, ins[5:0]};
    xd = rf_vals[ins[11:9]];
    nt = 0; ewb = 0; euns = 0; edata = 16'h0; tag = "R10";
    ta[0] = 0; ta[1] = 0; tw[0] = 0; tw[1] = 0; twe[0] = 0; twe[1] = 0;
    case (op)
      4'b0010: begin ea = pc + s9; tag = "R2"; nt = 1; ta[0] = ea; ewb = 1; edata = memf(ea); end
      4'b0011: begin ea = pc + s9; tag = "R2"; nt = 1; ta[0] = ea; twe[0] = 1; tw[0] = xd; end
      4'b0110: begin ea = rf_vals[ins[8:6]] + s6; tag = "R3"; nt = 1; ta[0] = ea; ewb = 1; edata = memf(ea); end
      4'b0111: begin ea = rf_vals[ins[8:6]] + s6; tag = "R3"; nt = 1; ta[0] = ea; twe[0] = 1; tw[0] = xd; end
      4'b1010: begin ea = pc + s9; ptr = memf(ea); tag = "R4"; nt = 2; ta[0] = ea; ta[1] = ptr;
                     ewb = 1; edata = memf(ptr); end
      4'b1011: begin ea = pc + s9; ptr = memf(ea); tag = "R5"; nt = 2; ta[0] = ea; ta[1] = ptr;
                     twe[1] = 1; tw[1] = xd; end
      4'b1110: begin tag = "R6"; ewb = 1; edata = pc + s9; end
      default: euns = 1;
    endcase
    elat = 2 + nt + nt * lat;

    @(negedge clk);
    mem_lat = lat; nlog = 0; instr = ins; pc_next = pc; start = 1'b1;
    @(negedge clk);
    start = 1'b0; cyc = 1;
    while (!done && cyc < 40) begin @(negedge clk); cyc++; end
    chk("R9", "done latency", 16'(cyc), 16'(elat));
    chk(tag, "wb_en", {15'h0, wb_en}, {15'h0, ewb});
    chk("R10", "unsupported", {15'h0, unsupported}, {15'h0, euns});
    if (ewb) begin
      chk(tag, "wb_idx", {13'h0, wb_idx}, {13'h0, ins[11:9]});
      chk(tag, "wb_data", wb_data, edata);
    end
    chk(tag, "access count", 16'(nlog), 16'(nt));
    for (int k = 0; k < nt && k < nlog; k++) begin
      chk(tag, "access addr", log_addr[k], ta[k]);
      chk(twe[k] ? "R7" : tag, "access we", {15'h0, log_we[k]}, {15'h0, twe[k]});
      if (twe[k]) chk("R7", "store data", log_wd[k], tw[k]);
    end
    @(negedge clk);
    chk("R9", "done one cycle", {15'h0, done}, 16'h0);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog run did not complete");
    summary();
  end

  initial begin
    logic [8:0] offs [4];
    logic [15:0] pcs [2];
    offs[0] = 9'h0FF; offs[1] = 9'h100; offs[2] = 9'h000; offs[3] = 9'h1C5;
    pcs[0] = 16'h3001; pcs[1] = 16'hFFF8;
    for (int i = 0; i < 8; i++) rf_vals[i] = 16'(i * 16'h2345) ^ 16'hF00F;
    rf_vals[5] = 16'hFFFE;
    rst_n = 1'b0; start = 1'b0; instr = 16'h0; pc_next = 16'h0;
    mem_ready = 1'b0; mem_rdata = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "done after reset", {15'h0, done}, 16'h0);
    chk("R1", "mem_req after reset", {15'h0, mem_req}, 16'h0);
    chk("R1", "wb_en after reset", {15'h0, wb_en}, 16'h0);
    chk("R1", "unsupported after reset", {15'h0, unsupported}, 16'h0);

    run({4'b1110, 3'd1, 9'h0FF}, 16'h3001, 0);
    chk("R6", "x3001+0FF", wb_data, 16'h3100);

    for (int op = 0; op < 16; op++)
      for (int o = 0; o < 4; o++)
        for (int p = 0; p < 2; p++)
          for (int l = 0; l < 2; l++)
            run({4'(op), 3'(op + o), offs[o]}, pcs[p], l * 2);

    chk("R8", "request held stable while waiting", 16'(hold_err), 16'h0);
    summary();
  end
endmodule